// File: doc/BRIEF.md
# Expansion Bus Slot Identification Scanner

This block walks every slot of a serial expansion bus that has several channels with several devices each, and finds out which slots hold a device. For each slot it pulls that slot's active-low select line, clocks out a 16-bit identify command, clocks in a 32-bit identifier, and then releases the select. Slots answer in SPI mode 0: the serial clock idles low, the block samples on the rising edge, and data changes on the falling edge.

An identifier of all zeros or all ones means nothing answered, so the slot counts as empty. Any other identifier marks the slot occupied and is kept. A skip mask lets the caller leave out slots it already knows about. The results are a per-slot presence bitmap, a combinational identifier read port and a one-cycle completion pulse. All serial traffic runs at a fixed, slow probe rate, set by a system-clock divider.

Top module: `id_scan_top`

## Requirements
- R1: While and after reset, with no start: `present_o` is all zeros, `done_o` and `busy_o` are low, every `cs_n_o` bit is high, and `sclk_o` and `mosi_o` are all low.
- R2: Slots are probed channel-major. The slot number is channel*NDEV+device, so the order runs channel 0 devices 0..2, then channel 1, then channel 2. `cs_n_o[slot]` is that slot's select, and at most one select is low at any time.
- R3: One probe is a single select assertion holding exactly 48 rising edges of the selected channel's `sclk_o`. The first 16 edges carry the identify command 0x0000 on `mosi_o`, MSB first. The last 32 edges sample `miso_i`, and `sclk_o` ends low.
- R4: The identifier is assembled MSB first, so the first bit sampled lands in bit 31. `rd_id_o` returns the identifier stored for slot `rd_slot_i`, and returns 0 for a slot number of NCHAN*NDEV or more.
- R5: An identifier of 0x00000000 or 0xFFFFFFFF clears the slot's `present_o` bit and stores 0. Any other value, including 0x00000001 and 0xFFFFFFFE, sets `present_o` and stores the value unchanged.
- R6: A slot whose `skip_i` bit is set at the start of a scan is never selected, and its `present_o` bit and stored identifier stay unchanged.
- R7: Between two consecutive probes, all selects stay high for at least two serial clock periods (4*HALF_DIV system cycles).
- R8: The serial clock period is 2*HALF_DIV system cycles. Consecutive rising edges within a probe are exactly that far apart.
- R9: `busy_o` is high during a scan. After the last slot has been handled, `done_o` goes high for exactly one cycle. This includes a scan in which every slot is skipped.
- R10: A start pulse that arrives while `busy_o` is high is ignored. The scan neither restarts nor revisits a slot.
- R11: A channel that is not being probed keeps its `sclk_o` and `mosi_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a scan |
| skip_i | input | NCHAN*NDEV | Slots to leave unprobed, one bit per slot |
| rd_slot_i | input | $clog2(NCHAN*NDEV) | Slot number for the identifier read port |
| miso_i | input | NCHAN | Serial data from devices, one line per channel |
| sclk_o | output | NCHAN | Serial clock, one line per channel |
| mosi_o | output | NCHAN | Serial data to devices, one line per channel |
| cs_n_o | output | NCHAN*NDEV | Active-low device selects, one per slot |
| present_o | output | NCHAN*NDEV | Slot occupied bitmap |
| rd_id_o | output | 32 | Stored identifier of slot `rd_slot_i` |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at the end of a scan |

## Verification
The hardest situation to reach from the ports is a second start pulse that lands in the middle of a probe, while the bit engine is part way through a word. The bench fires one several hundred cycles into a scan. It then checks that the expected sequence of selected slots still matches with no extra visit to slot 0, and that only one completion pulse appears. Skipped slots are checked by re-scanning with new device identifiers behind the skipped slots and confirming through the read port that the old values are still there. The identifiers around the empty codes (all zeros, all ones, and their neighbours 1 and 0xFFFFFFFE) exercise the occupancy boundary.

// File: rtl/id_scan_pkg.sv
package id_scan_pkg;
  localparam int ID_W  = 32;
  localparam int CMD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PICK, ST_SETUP, ST_XFER, ST_HOLD, ST_GAP, ST_DONE
  } scan_state_e;

  // Empty-slot codes: nothing answered (bus floats low or high).
  function automatic logic id_is_blank(input logic [ID_W-1:0] v);
    return (v == '0) || (&v);
  endfunction

  // Channel-major linear slot number.
  function automatic int unsigned slot_index(input int unsigned ch,
                                             input int unsigned dv,
                                             input int unsigned ndev);
    return ch * ndev + dv;
  endfunction
endpackage

// File: rtl/id_scan_timer.sv
module id_scan_timer #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF_DIV + 1);
  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(HALF_DIV)); // R8
endmodule

// File: rtl/id_scan_shift.sv
module id_scan_shift #(
  parameter int               CMD_W = 16,
  parameter int               ID_W  = 32,
  parameter logic [CMD_W-1:0] CMD   = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            run_i,
  input  logic            tick_i,
  input  logic            miso_i,
  output logic            sclk_o,
  output logic            mosi_o,
  output logic            fin_o,
  output logic [ID_W-1:0] rx_o
);
  localparam int TOT = CMD_W + ID_W;
  localparam int BW  = $clog2(TOT + 1);

  logic [BW-1:0]    bit_q;
  logic [CMD_W-1:0] tx_q;
  logic [ID_W-1:0]  rx_q;
  logic             sclk_q;
  logic             ev_rise, ev_fall, in_id_phase;

  assign ev_rise     = run_i && tick_i && !sclk_q;
  assign ev_fall     = run_i && tick_i &&  sclk_q;
  assign in_id_phase = bit_q >= BW'(CMD_W);
  assign fin_o       = ev_fall && (bit_q == BW'(TOT - 1));
  assign sclk_o      = sclk_q;
  assign mosi_o      = tx_q[CMD_W-1];
  assign rx_o        = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (load_i) begin
      sclk_q <= 1'b0;
      bit_q  <= '0;
      tx_q   <= CMD;
      rx_q   <= '0;
    end else if (ev_rise) begin
      sclk_q <= 1'b1;
      if (in_id_phase) rx_q <= {rx_q[ID_W-2:0], miso_i};
    end else if (ev_fall) begin
      sclk_q <= 1'b0;
      bit_q  <= bit_q + 1'b1;
      tx_q   <= {tx_q[CMD_W-2:0], 1'b0};
    end
  end

  AST_CMD_PHASE_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rise && !in_id_phase && !load_i) |=> $stable(rx_q)); // R4
  AST_END_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !sclk_q); // R3
endmodule

// File: rtl/id_scan_store.sv
module id_scan_store
  import id_scan_pkg::*;
#(
  parameter int SLOTS = 9,
  parameter int SW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [SW-1:0]    wr_slot_i,
  input  logic [ID_W-1:0]  wr_id_i,
  input  logic [SW-1:0]    rd_slot_i,
  output logic [SLOTS-1:0] present_o,
  output logic [ID_W-1:0]  rd_id_o
);
  logic [ID_W-1:0] id_q [SLOTS];
  logic            blank;

  assign blank = id_is_blank(wr_id_i);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        present_o[s] <= 1'b0;
        id_q[s]      <= '0;
      end else if (wr_i && wr_slot_i == SW'(s)) begin
        present_o[s] <= !blank;
        id_q[s]      <= blank ? '0 : wr_id_i;
      end
    end
  end

  always_comb begin
    rd_id_o = '0;
    for (int s = 0; s < SLOTS; s++)
      if (rd_slot_i == SW'(s)) rd_id_o = id_q[s];
  end

  AST_STORE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (present_o[$past(wr_slot_i)] == !id_is_blank($past(wr_id_i)))); // R5
endmodule

// File: rtl/id_scan_top.sv
module id_scan_top
  import id_scan_pkg::*;
#(
  parameter int               NCHAN    = 3,
  parameter int               NDEV     = 3,
  parameter int               HALF_DIV = 3,
  parameter int               GAP_SCLK = 2,
  parameter logic [CMD_W-1:0] ID_CMD   = 16'h0000,
  localparam int              SLOTS    = NCHAN * NDEV,
  localparam int              SW       = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SLOTS-1:0] skip_i,
  input  logic [SW-1:0]    rd_slot_i,
  input  logic [NCHAN-1:0] miso_i,
  output logic [NCHAN-1:0] sclk_o,
  output logic [NCHAN-1:0] mosi_o,
  output logic [SLOTS-1:0] cs_n_o,
  output logic [SLOTS-1:0] present_o,
  output logic [ID_W-1:0]  rd_id_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int CW         = (NCHAN > 1) ? $clog2(NCHAN) : 1;
  localparam int DW         = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam int GAP_HALVES = 2 * GAP_SCLK;
  localparam int GW         = $clog2(GAP_HALVES + 1);

  scan_state_e   state_q;
  logic [CW-1:0] chan_q;
  logic [DW-1:0] dev_q;
  logic [GW-1:0] gap_q;
  logic [SW-1:0] cur_slot;

  // Named internal events
  logic tick, ev_start, ev_skip, ev_probe, ev_store, ev_advance, last_slot;
  logic cs_active, eng_sclk, eng_mosi, eng_fin, miso_sel;
  logic [ID_W-1:0] eng_rx;

  assign cur_slot   = SW'(slot_index(chan_q, dev_q, NDEV));
  assign last_slot  = (chan_q == CW'(NCHAN - 1)) && (dev_q == DW'(NDEV - 1));
  assign ev_start   = (state_q == ST_IDLE) && start_i;
  assign ev_skip    = (state_q == ST_PICK) &&  skip_i[cur_slot];
  assign ev_probe   = (state_q == ST_PICK) && !skip_i[cur_slot];
  assign ev_store   = (state_q == ST_HOLD) && tick;
  assign ev_advance = ((ev_skip) ||
                       (state_q == ST_GAP && tick && gap_q == GW'(GAP_HALVES - 1)));
  assign cs_active  = (state_q == ST_SETUP) || (state_q == ST_XFER) || (state_q == ST_HOLD);
  assign miso_sel   = miso_i[chan_q];
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  id_scan_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .en_i(cs_active || state_q == ST_GAP),
    .tick_o(tick)
  );

  id_scan_shift #(.CMD_W(CMD_W), .ID_W(ID_W), .CMD(ID_CMD)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load_i(ev_probe), .run_i(state_q == ST_XFER), .tick_i(tick),
    .miso_i(miso_sel), .sclk_o(eng_sclk), .mosi_o(eng_mosi),
    .fin_o(eng_fin), .rx_o(eng_rx)
  );

  id_scan_store #(.SLOTS(SLOTS), .SW(SW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_i(ev_store), .wr_slot_i(cur_slot), .wr_id_i(eng_rx),
    .rd_slot_i(rd_slot_i), .present_o(present_o), .rd_id_o(rd_id_o)
  );

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    assign sclk_o[c] = cs_active && (chan_q == CW'(c)) && eng_sclk;
    assign mosi_o[c] = cs_active && (chan_q == CW'(c)) && eng_mosi;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_cs
    assign cs_n_o[s] = !(cs_active && cur_slot == SW'(s));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      dev_q   <= '0;
      gap_q   <= '0;
    end else begin
      if (ev_advance && !last_slot) begin
        if (dev_q == DW'(NDEV - 1)) begin
          dev_q  <= '0;
          chan_q <= chan_q + 1'b1;
        end else begin
          dev_q <= dev_q + 1'b1;
        end
      end
      unique case (state_q)
        ST_IDLE:  if (ev_start) begin
                    chan_q  <= '0;
                    dev_q   <= '0;
                    state_q <= ST_PICK;
                  end
        ST_PICK:  if (ev_skip) state_q <= last_slot ? ST_DONE : ST_PICK;
                  else         state_q <= ST_SETUP;
        ST_SETUP: if (tick)    state_q <= ST_XFER;
        ST_XFER:  if (eng_fin) state_q <= ST_HOLD;
        ST_HOLD:  if (tick) begin
                    gap_q   <= '0;
                    state_q <= ST_GAP;
                  end
        ST_GAP:   if (tick) begin
                    if (ev_advance) state_q <= last_slot ? ST_DONE : ST_PICK;
                    else            gap_q   <= gap_q + 1'b1;
                  end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o)); // R2
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n_o) |-> (sclk_o == '0 && mosi_o == '0)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> (cur_slot >= $past(cur_slot))); // R10
  AST_SKIP_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> (&cs_n_o)); // R6
endmodule

// File: tb/test_id_scan_top.sv
module test_id_scan_top;
  localparam int NCHAN = 3, NDEV = 3, SLOTS = 9, HALF = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [SLOTS-1:0] skip_i = '0;
  logic [3:0]       rd_slot_i = '0;
  logic [NCHAN-1:0] miso_i = '0;
  logic [NCHAN-1:0] sclk_o, mosi_o;
  logic [SLOTS-1:0] cs_n_o, present_o;
  logic [31:0]      rd_id_o;
  logic             busy_o, done_o;

  id_scan_top i_id_scan_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .skip_i(skip_i),
    .rd_slot_i(rd_slot_i), .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .cs_n_o(cs_n_o), .present_o(present_o), .rd_id_o(rd_id_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always #10 clk = ~clk; // 50 MHz

  int checks = 0, fails = 0, cyc = 0, done_cnt = 0;
  logic [31:0] dev_id [SLOTS];
  logic [31:0] exp_id [SLOTS];
  logic        exp_present [SLOTS];
  int          exp_visit [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Monitor: slave model and scoreboard consumer
  int  act_slot = -1, rises = 0, mosi_bad = 0, last_rise = 0, gap_len = 0;
  bit  seen_gap = 0;
  bit  prev_sclk = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      act_slot = -1;
    end else begin
      if (done_o) done_cnt++;
      if (act_slot < 0) begin
        if (!(&cs_n_o)) begin
          for (int s = 0; s < SLOTS; s++) if (!cs_n_o[s]) act_slot = s;
          if (exp_visit.size() == 0)
            check(0, "R10 R2 unexpected select", act_slot, -1);
          else begin
            int e;
            e = exp_visit.pop_front();
            check(act_slot == e, "R2 R6 visit order", act_slot, e);
          end
          if (seen_gap) check(gap_len >= 4*HALF, "R7 select gap", gap_len, 4*HALF);
          rises = 0; mosi_bad = 0; prev_sclk = 0;
          miso_i = '0;
        end else gap_len++;
      end else begin
        int ch;
        ch = act_slot / NDEV;
        if (cs_n_o[act_slot]) begin
          check(rises == 48, "R3 edges per probe", rises, 48);
          check(mosi_bad == 0, "R3 command bits", mosi_bad, 0);
          act_slot = -1; seen_gap = 1; gap_len = 1; miso_i = '0;
        end else begin
          if (sclk_o[ch] && !prev_sclk) begin
            if (rises > 0) check(cyc - last_rise == 2*HALF, "R8 sclk period", cyc - last_rise, 2*HALF);
            last_rise = cyc;
            if (rises < 16 && mosi_o[ch] !== 1'b0) mosi_bad++;
            rises++;
          end else if (!sclk_o[ch] && prev_sclk) begin
            if (rises >= 16 && rises < 48) miso_i[ch] = dev_id[act_slot][31 - (rises - 16)];
            else miso_i[ch] = 1'b0;
          end
          prev_sclk = sclk_o[ch];
        end
      end
    end
  end

  // Driver: predicts results, pushes expected visits, runs a scan
  task automatic run_scan(input logic [SLOTS-1:0] skip, input bit mid_start, input string tag);
    int d0, waited;
    for (int s = 0; s < SLOTS; s++) if (!skip[s]) begin
      exp_visit.push_back(s);
      if (dev_id[s] == 32'h0 || dev_id[s] == 32'hFFFF_FFFF) begin
        exp_present[s] = 0; exp_id[s] = 0;
      end else begin
        exp_present[s] = 1; exp_id[s] = dev_id[s];
      end
    end
    seen_gap = 0;
    d0 = done_cnt;
    @(negedge clk); skip_i = skip; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(busy_o == 1'b1, {"R9 busy ", tag}, busy_o, 1);
    if (mid_start) begin
      repeat (400) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    end
    waited = 0;
    while (!done_o && waited < 20000) begin @(negedge clk); waited++; end
    check(done_o == 1'b1, {"R9 done seen ", tag}, done_o, 1);
    @(negedge clk);
    check(done_o == 1'b0 && busy_o == 1'b0, {"R9 done one cycle ", tag}, done_o, 0);
    repeat (3) @(negedge clk);
    check(done_cnt - d0 == 1, {"R9 R10 done count ", tag}, done_cnt - d0, 1);
    check(exp_visit.size() == 0, {"R2 all visits seen ", tag}, exp_visit.size(), 0);
    exp_visit.delete();
    for (int s = 0; s < SLOTS; s++) begin
      rd_slot_i = 4'(s); #1;
      check(present_o[s] == exp_present[s], {"R5 R6 present ", tag}, present_o[s], exp_present[s]);
      check(rd_id_o == exp_id[s], {"R4 R5 R6 id ", tag}, rd_id_o, exp_id[s]);
    end
  endtask

  initial begin
    for (int s = 0; s < SLOTS; s++) begin dev_id[s] = '0; exp_id[s] = '0; exp_present[s] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(present_o == '0 && done_o == 0 && busy_o == 0, "R1 reset flags", present_o, 0);
    check(&cs_n_o && sclk_o == '0 && mosi_o == '0, "R1 reset lines", cs_n_o, 9'h1FF);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(&cs_n_o && busy_o == 0 && present_o == '0, "R1 idle after reset", cs_n_o, 9'h1FF);

    // Scenario A: all slots empty (R5 boundary codes)
    for (int s = 0; s < SLOTS; s++) dev_id[s] = (s % 2) ? 32'hFFFF_FFFF : 32'h0;
    run_scan('0, 0, "empty");

    // Scenario B: mixed identifiers, boundary neighbours (R4 R5)
    dev_id[0] = 32'h0000_0001; dev_id[1] = 32'h0;         dev_id[2] = 32'hFFFF_FFFE;
    dev_id[3] = 32'h8000_0000; dev_id[4] = 32'hFFFF_FFFF; dev_id[5] = 32'hA5C3_0F1E;
    dev_id[6] = 32'h0;         dev_id[7] = 32'h1234_5678; dev_id[8] = 32'h0000_0101;
    run_scan('0, 0, "mixed");

    // Scenario C: skip known slots with changed devices behind them (R6)
    dev_id[0] = 32'hDEAD_0000; dev_id[5] = 32'h0; dev_id[7] = 32'hFFFF_FFFF;
    dev_id[1] = 32'h0BAD_F00D; dev_id[8] = 32'h0;
    run_scan(9'b0_1010_0001, 0, "skip");

    // Scenario D: start pulse mid-scan ignored (R10)
    dev_id[4] = 32'h4444_4444;
    run_scan('0, 1, "restart");

    // Scenario E: every slot skipped (R6 R9)
    for (int s = 0; s < SLOTS; s++) dev_id[s] = 32'h7777_0000 + 32'(s);
    run_scan('1, 0, "allskip");

    // Out-of-range read returns zero (R4)
    rd_slot_i = 4'd12; #1;
    check(rd_id_o == 32'h0, "R4 out-of-range read", rd_id_o, 0);
    // Idle channels quiet (R11)
    check(sclk_o == '0 && mosi_o == '0, "R11 idle lines", sclk_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule